// File: doc/BRIEF.md
# Parallel Flash Page Programming Sequencer

This block runs on the host side of a byte-wide parallel flash bus and programs the array one page at a time. A start request supplies a start address, a page count and a verify select. The sequencer puts the flash into identification mode, reads the device code and leaves identification mode. It then derives the page size from that code. Each page is written as a three-byte unlock command followed by the page bytes, which are taken from a local valid/ready byte stream.

Completion of each page is found by reading back the last byte written until it matches, and a watchdog bounds this loop. When verify is selected, every byte of the page is read back and compared with a local copy before the next page starts. The result is reported by sticky done, error and timeout flags, together with the failing address when verify finds a mismatch.

Top module: `flash_page_prog`

## Requirements
- R1: After a start request the first bus writes are data 0xAA at address 0x5555, 0x55 at 0x2AAA and 0x90 at 0x5555. At least TWC_CYC clocks later the device code is read at address 0x0001.
- R2: After the code read the sequencer writes 0xAA at 0x5555, 0x55 at 0x2AAA and 0xF0 at 0x5555. It then waits at least TWC_CYC clocks before any further bus write.
- R3: The page size is decoded from the device code: 0xDC or 0xBC gives 64 bytes; 0x5D, 0x3D, 0xD5, 0x35, 0x25 or 0x26 gives 128; 0xDA or 0xBA gives 256; 0xA4 or 0xC4 gives 512. Any other code ends the operation with done=1 and error=1, with no page unlock written.
- R4: Each page begins with 0xAA at 0x5555, 0x55 at 0x2AAA and 0xA0 at 0x5555. Next come one write per byte at base+0, base+1 and so on, in ascending order. The first base is the start address rounded down to the page size, and each later page sits directly above the previous one. A page count of zero is treated as one.
- R5: Every write pulse holds output enable high and chip enable low while write enable is low, and write enable stays low for exactly WE_CYC clocks. With the source always valid, successive page byte writes are spaced WE_CYC+2 clocks apart.
- R6: A source byte is consumed only on a clock where srcValid and srcReady are both high. A stalled source delays the load without losing or repeating bytes.
- R7: After the last byte of a page, the sequencer reads only the last written address until the value read equals the byte written there. With verify off, it then moves to the next page.
- R8: If the polling loop has not matched within WDOG_CYC clocks, the operation ends with done=1, timeout=1 and error=0, and no further bus writes occur.
- R9: With verify on, every address of the page is read after polling completes. A mismatch ends the operation with done=1 and error=1, errAddr holds the failing address, and no later page is written.
- R10: During and after reset, flCeN, flOeN and flWeN are high and busy, done, error and timeout are low.
- R11: After the final page completes, done=1, error=0, timeout=0 and busy=0, and the flags hold until the next start request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start pulse, accepted while idle |
| startAddr | input | ADDR_W | Start address of the first page |
| pageCnt | input | CNT_W | Number of pages to program (0 means 1) |
| verifyEn | input | 1 | Read back and compare each page |
| srcValid | input | 1 | Source byte valid |
| srcData | input | 8 | Source byte |
| srcReady | output | 1 | Sequencer accepts a source byte |
| flAddr | output | ADDR_W | Flash address |
| flDout | output | 8 | Data driven to flash |
| flDoe | output | 1 | Data bus drive enable |
| flDin | input | 8 | Data read from flash |
| flCeN | output | 1 | Chip enable, active low |
| flOeN | output | 1 | Output enable, active low |
| flWeN | output | 1 | Write enable, active low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (sticky) |
| error | output | 1 | Unknown device code or verify mismatch (sticky) |
| timeout | output | 1 | Polling watchdog expired (sticky) |
| errAddr | output | ADDR_W | Address of the verify mismatch |

## Verification
The bench targets page-size decoding and address alignment. A misaligned start address must round down to the page boundary; if the decode picked the wrong size, the bench would see the wrong byte count or pages overlapping in the write log. It also checks an unknown device code, where a faulty design would go on to write an unlock and page data. A flash model that never finishes programming shows whether a design polls forever or times out. A deliberately corrupted byte in the first of two pages must stop the second page and report that exact address, and a source that stalls in the middle of a page must not drop or repeat any byte.

// File: rtl/fpp_pkg.sv
package fpp_pkg;

  typedef enum logic [1:0] {CMD_ID_ENTER, CMD_ID_EXIT, CMD_UNLOCK} cmdKind_t;
  typedef enum logic [2:0] {BUS_CMD, BUS_ID, BUS_LOAD, BUS_POLL, BUS_VER} busSel_t;

  typedef struct packed {
    logic     ldStart;
    logic     ldCode;
    logic     setBase;
    logic     takeByte;
    logic     incOff;
    logic     clrOff;
    logic     nextPage;
    logic     wdClr;
    logic     wdRun;
    logic     latchErr;
    busSel_t  busSel;
    cmdKind_t cmdKind;
    logic [1:0] cmdIdx;
  } strobe_t;

  // log2 of the page size for a device code, 0 for an unknown code
  function automatic logic [3:0] sizeLog2(input logic [7:0] code);
    case (code)
      8'hDC, 8'hBC:                             return 4'd6;
      8'h5D, 8'h3D, 8'hD5, 8'h35, 8'h25, 8'h26: return 4'd7;
      8'hDA, 8'hBA:                             return 4'd8;
      8'hA4, 8'hC4:                             return 4'd9;
      default:                                  return 4'd0;
    endcase
  endfunction

  function automatic logic [15:0] cmdAddr(input logic [1:0] idx);
    return (idx == 2'd1) ? 16'h2AAA : 16'h5555;
  endfunction

  function automatic logic [7:0] cmdData(input cmdKind_t kind, input logic [1:0] idx);
    if (idx == 2'd0) return 8'hAA;
    if (idx == 2'd1) return 8'h55;
    case (kind)
      CMD_ID_ENTER: return 8'h90;
      CMD_ID_EXIT:  return 8'hF0;
      default:      return 8'hA0;
    endcase
  endfunction

endpackage

// File: rtl/fpp_dpath.sv
module fpp_dpath
  import fpp_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int CNT_W    = 8,
  parameter int MAX_PAGE = 512,
  parameter int WDOG_CYC = 4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  pageCnt,
  input  logic [7:0]        srcData,
  input  logic [7:0]        flDin,
  output logic [ADDR_W-1:0] flAddr,
  output logic [7:0]        flDout,
  output logic              codeOk,
  output logic              lastOff,
  output logic              lastPage,
  output logic              pollMatch,
  output logic              verMatch,
  output logic              wdExpired,
  output logic [ADDR_W-1:0] errAddr
);

  localparam int OFF_W = $clog2(MAX_PAGE);
  localparam int WD_W  = $clog2(WDOG_CYC + 1);

  logic [ADDR_W-1:0] startReg, base, curAddr;
  logic [CNT_W-1:0]  pagesLeft;
  logic [3:0]        sizeLog;
  logic [OFF_W-1:0]  off;
  logic [OFF_W:0]    pageLen, pageMask;
  logic [7:0]        wrData;
  logic [7:0]        pageBuf [MAX_PAGE];
  logic [WD_W-1:0]   wdCnt;

  assign pageLen   = (OFF_W+1)'(1) << sizeLog;
  assign pageMask  = pageLen - 1'b1;
  assign codeOk    = (sizeLog != 4'd0) && (int'(sizeLog) <= OFF_W);
  assign lastOff   = ({1'b0, off} == pageMask);
  assign lastPage  = (pagesLeft == CNT_W'(1));
  assign curAddr   = base + ADDR_W'(off);
  assign pollMatch = (flDin == wrData);
  assign verMatch  = (flDin == pageBuf[off]);
  assign wdExpired = (wdCnt >= WD_W'(WDOG_CYC));

  always_comb begin
    case (stb.busSel)
      BUS_CMD: flAddr = ADDR_W'(cmdAddr(stb.cmdIdx));
      BUS_ID:  flAddr = ADDR_W'(1);
      default: flAddr = curAddr;
    endcase
    flDout = (stb.busSel == BUS_CMD) ? cmdData(stb.cmdKind, stb.cmdIdx) : wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startReg  <= '0;
      base      <= '0;
      pagesLeft <= '0;
      sizeLog   <= '0;
      off       <= '0;
      wrData    <= '0;
      wdCnt     <= '0;
      errAddr   <= '0;
    end else begin
      if (stb.ldStart) begin
        startReg  <= startAddr;
        pagesLeft <= (pageCnt == '0) ? CNT_W'(1) : pageCnt;
        sizeLog   <= '0;
        off       <= '0;
      end
      if (stb.ldCode)   sizeLog <= sizeLog2(flDin);
      if (stb.setBase) begin
        base <= startReg & ~ADDR_W'(pageMask);
        off  <= '0;
      end
      if (stb.nextPage) begin
        base      <= base + ADDR_W'(pageLen);
        off       <= '0;
        pagesLeft <= pagesLeft - 1'b1;
      end
      if (stb.clrOff)   off <= '0;
      if (stb.incOff)   off <= off + 1'b1;
      if (stb.takeByte) wrData <= srcData;
      if (stb.wdClr)    wdCnt <= '0;
      else if (stb.wdRun && !wdExpired) wdCnt <= wdCnt + 1'b1;
      if (stb.latchErr) errAddr <= curAddr;
    end
  end

  // local copy of the page for read-back compare
  always_ff @(posedge clk) begin
    if (stb.takeByte) pageBuf[off] <= srcData;
  end

  // R4: the byte offset never leaves the decoded page
  assert_off_in_page_R4: assert property (@(posedge clk) disable iff (!rstN)
    codeOk |-> ({1'b0, off} <= pageMask));

  // R8: the watchdog count saturates at its limit
  assert_wdog_bounded_R8: assert property (@(posedge clk) disable iff (!rstN)
    wdCnt <= WD_W'(WDOG_CYC));

endmodule

// File: rtl/fpp_ctrl.sv
module fpp_ctrl
  import fpp_pkg::*;
#(
  parameter int WE_CYC  = 4,
  parameter int RD_CYC  = 2,
  parameter int TWC_CYC = 64
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    verifyEn,
  input  logic    srcValid,
  input  logic    codeOk,
  input  logic    lastOff,
  input  logic    lastPage,
  input  logic    pollMatch,
  input  logic    verMatch,
  input  logic    wdExpired,
  output strobe_t stb,
  output logic    srcReady,
  output logic    flCeN,
  output logic    flOeN,
  output logic    flWeN,
  output logic    flDoe,
  output logic    busy,
  output logic    done,
  output logic    error,
  output logic    timeout
);

  localparam int TMAX = (TWC_CYC > WE_CYC + 2) ? ((TWC_CYC > RD_CYC) ? TWC_CYC : RD_CYC)
                                               : ((WE_CYC + 2 > RD_CYC) ? WE_CYC + 2 : RD_CYC);
  localparam int TM_W = $clog2(TMAX + 1);
  localparam logic [TM_W-1:0] WR_LAST  = TM_W'(WE_CYC + 1);
  localparam logic [TM_W-1:0] WE_END   = TM_W'(WE_CYC);
  localparam logic [TM_W-1:0] RD_LAST  = TM_W'(RD_CYC - 1);
  localparam logic [TM_W-1:0] TWC_LAST = TM_W'(TWC_CYC - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_TWC, S_IDRD, S_DECODE, S_LOAD, S_POLLCK, S_POLLRD, S_VERRD, S_NEXT
  } state_t;

  state_t     state, stateN;
  logic [TM_W-1:0] tmr, tmrN;
  cmdKind_t   kind, kindN;
  logic [1:0] idx, idxN;
  logic       verReg, verN, doneN, errN, tmoN;
  logic       wrPhase, rdPhase;
  logic [TM_W-1:0] weLowCnt;

  assign wrPhase  = (state == S_CMD) || (state == S_LOAD);
  assign rdPhase  = (state == S_IDRD) || (state == S_POLLRD) || (state == S_VERRD);
  assign flCeN    = !((wrPhase && tmr != '0) || rdPhase);
  assign flWeN    = !(wrPhase && tmr != '0 && tmr <= WE_END);
  assign flOeN    = !rdPhase;
  assign flDoe    = wrPhase;
  assign srcReady = (state == S_LOAD) && (tmr == '0);
  assign busy     = (state != S_IDLE);

  always_comb begin
    stb         = '0;
    stb.cmdKind = kind;
    stb.cmdIdx  = idx;
    case (state)
      S_CMD:              stb.busSel = BUS_CMD;
      S_IDRD:             stb.busSel = BUS_ID;
      S_POLLCK, S_POLLRD: stb.busSel = BUS_POLL;
      S_VERRD:            stb.busSel = BUS_VER;
      default:            stb.busSel = BUS_LOAD;
    endcase
    stateN = state;
    tmrN   = tmr + 1'b1;
    kindN  = kind;
    idxN   = idx;
    verN   = verReg;
    doneN  = done;
    errN   = error;
    tmoN   = timeout;
    case (state)
      S_IDLE: begin
        tmrN = '0;
        if (startReq) begin
          stb.ldStart = 1'b1;
          stateN = S_CMD;
          kindN  = CMD_ID_ENTER;
          idxN   = 2'd0;
          verN   = verifyEn;
          doneN  = 1'b0;
          errN   = 1'b0;
          tmoN   = 1'b0;
        end
      end
      S_CMD: if (tmr == WR_LAST) begin
        tmrN = '0;
        if (idx == 2'd2) begin
          idxN   = 2'd0;
          stateN = (kind == CMD_UNLOCK) ? S_LOAD : S_TWC;
        end else begin
          idxN = idx + 1'b1;
        end
      end
      S_TWC: if (tmr == TWC_LAST) begin
        tmrN   = '0;
        stateN = (kind == CMD_ID_ENTER) ? S_IDRD : S_DECODE;
      end
      S_IDRD: if (tmr == RD_LAST) begin
        tmrN       = '0;
        stb.ldCode = 1'b1;
        stateN     = S_CMD;
        kindN      = CMD_ID_EXIT;
      end
      S_DECODE: begin
        tmrN = '0;
        if (codeOk) begin
          stb.setBase = 1'b1;
          stateN = S_CMD;
          kindN  = CMD_UNLOCK;
        end else begin
          errN   = 1'b1;
          doneN  = 1'b1;
          stateN = S_IDLE;
        end
      end
      S_LOAD: begin
        if (tmr == '0) begin
          tmrN         = srcValid ? TM_W'(1) : '0;
          stb.takeByte = srcValid;
        end else if (tmr == WR_LAST) begin
          tmrN = '0;
          if (lastOff) begin
            stb.wdClr = 1'b1;
            stateN    = S_POLLCK;
          end else begin
            stb.incOff = 1'b1;
          end
        end
      end
      S_POLLCK: begin
        tmrN      = '0;
        stb.wdRun = 1'b1;
        if (wdExpired) begin
          tmoN   = 1'b1;
          doneN  = 1'b1;
          stateN = S_IDLE;
        end else begin
          stateN = S_POLLRD;
        end
      end
      S_POLLRD: begin
        stb.wdRun = 1'b1;
        if (tmr == RD_LAST) begin
          tmrN = '0;
          if (!pollMatch)  stateN = S_POLLCK;
          else if (verReg) begin
            stb.clrOff = 1'b1;
            stateN = S_VERRD;
          end else         stateN = S_NEXT;
        end
      end
      S_VERRD: if (tmr == RD_LAST) begin
        tmrN = '0;
        if (!verMatch) begin
          stb.latchErr = 1'b1;
          errN   = 1'b1;
          doneN  = 1'b1;
          stateN = S_IDLE;
        end else if (lastOff) begin
          stateN = S_NEXT;
        end else begin
          stb.incOff = 1'b1;
        end
      end
      S_NEXT: begin
        tmrN = '0;
        if (lastPage) begin
          doneN  = 1'b1;
          stateN = S_IDLE;
        end else begin
          stb.nextPage = 1'b1;
          stateN = S_CMD;
          kindN  = CMD_UNLOCK;
        end
      end
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      tmr      <= '0;
      kind     <= CMD_ID_ENTER;
      idx      <= '0;
      verReg   <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
      timeout  <= 1'b0;
      weLowCnt <= '0;
    end else begin
      state    <= stateN;
      tmr      <= tmrN;
      kind     <= kindN;
      idx      <= idxN;
      verReg   <= verN;
      done     <= doneN;
      error    <= errN;
      timeout  <= tmoN;
      weLowCnt <= flWeN ? '0 : weLowCnt + 1'b1;
    end
  end

  // R5: write enable low only with chip enable low and output enable high
  assert_we_qualified_R5: assert property (@(posedge clk) disable iff (!rstN)
    !flWeN |-> (!flCeN && flOeN));

  // R5: every write pulse lasts exactly WE_CYC clocks
  assert_we_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flWeN) |-> (weLowCnt == WE_END));

  // R8: a timeout is only flagged once the watchdog has run out
  assert_timeout_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeout) |-> $past(wdExpired));

  // R9: a failure flag leaves the bus quiet and the sequencer idle
  assert_fail_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (error || timeout) |-> (!busy && flWeN));

  // R11: done is only shown when idle
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog
  import fpp_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int CNT_W    = 8,
  parameter int MAX_PAGE = 512,
  parameter int WE_CYC   = 4,
  parameter int RD_CYC   = 2,
  parameter int TWC_CYC  = 64,
  parameter int WDOG_CYC = 4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  pageCnt,
  input  logic              verifyEn,
  input  logic              srcValid,
  input  logic [7:0]        srcData,
  output logic              srcReady,
  output logic [ADDR_W-1:0] flAddr,
  output logic [7:0]        flDout,
  output logic              flDoe,
  input  logic [7:0]        flDin,
  output logic              flCeN,
  output logic              flOeN,
  output logic              flWeN,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              timeout,
  output logic [ADDR_W-1:0] errAddr
);

  strobe_t stb;
  logic codeOk, lastOff, lastPage, pollMatch, verMatch, wdExpired;

  fpp_ctrl #(.WE_CYC(WE_CYC), .RD_CYC(RD_CYC), .TWC_CYC(TWC_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .verifyEn(verifyEn),
    .srcValid(srcValid), .codeOk(codeOk), .lastOff(lastOff), .lastPage(lastPage),
    .pollMatch(pollMatch), .verMatch(verMatch), .wdExpired(wdExpired),
    .stb(stb), .srcReady(srcReady), .flCeN(flCeN), .flOeN(flOeN), .flWeN(flWeN),
    .flDoe(flDoe), .busy(busy), .done(done), .error(error), .timeout(timeout)
  );

  fpp_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_PAGE(MAX_PAGE), .WDOG_CYC(WDOG_CYC)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .startAddr(startAddr), .pageCnt(pageCnt),
    .srcData(srcData), .flDin(flDin), .flAddr(flAddr), .flDout(flDout),
    .codeOk(codeOk), .lastOff(lastOff), .lastPage(lastPage), .pollMatch(pollMatch),
    .verMatch(verMatch), .wdExpired(wdExpired), .errAddr(errAddr)
  );

endmodule

// File: tb/flash_page_prog_tb.sv
`timescale 1ns/1ps
module flash_page_prog_tb_top;

  localparam int ADDR_W = 17, CNT_W = 8, WE_CYC = 4, RD_CYC = 2, TWC_CYC = 64, WDOG_CYC = 4000;
  localparam int BLC_CYC = 1000;

  logic clk = 1'b0, rstN = 1'b0;
  logic startReq = 1'b0, verifyEn = 1'b0, srcValid = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [CNT_W-1:0]  pageCnt = '0;
  logic [7:0] srcData = '0, flDin = '0;
  logic srcReady, flDoe, flCeN, flOeN, flWeN, busy, done, error, timeout;
  logic [ADDR_W-1:0] flAddr, errAddr;
  logic [7:0] flDout;

  always #4 clk = ~clk;

  flash_page_prog #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WE_CYC(WE_CYC), .RD_CYC(RD_CYC),
                    .TWC_CYC(TWC_CYC), .WDOG_CYC(WDOG_CYC)) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startAddr(startAddr), .pageCnt(pageCnt),
    .verifyEn(verifyEn), .srcValid(srcValid), .srcData(srcData), .srcReady(srcReady),
    .flAddr(flAddr), .flDout(flDout), .flDoe(flDoe), .flDin(flDin), .flCeN(flCeN),
    .flOeN(flOeN), .flWeN(flWeN), .busy(busy), .done(done), .error(error),
    .timeout(timeout), .errAddr(errAddr)
  );

  int nChecks = 0, nErr = 0, cyc = 0;
  int wAddr[$], wData[$], wCyc[$], rAddr[$], rCyc[$];
  logic [7:0] mem [int];
  logic [7:0] pend [int];
  int devCode = 0, progCyc = 300, corruptAddr = -1;
  bit mId = 0, mLoad = 0, mBusy = 0, mPrevWe = 1, mPrevOe = 1, mTog = 0;
  int mSeq = 0, mIdle = 0, mCnt = 0, mPrevAddr = 0, ma = 0;
  logic [7:0] md, mLast = '0, rdVal;
  int weRun = 0, pulseViol = 0;
  bit feedStop = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int seed, int g);
    return 8'((g * 37 + seed + (g >> 3)) & 255);
  endfunction

  // behavioural flash model
  always @(posedge clk) begin
    cyc++;
    ma = int'(flAddr);
    md = flDout;
    if (flWeN && !mPrevWe && !flCeN) begin
      wAddr.push_back(ma); wData.push_back(int'(md)); wCyc.push_back(cyc);
      if (mLoad) begin pend[ma] = md; mLast = md; mIdle = 0; end
      else if (!mBusy) begin
        if (mSeq == 0) mSeq = (ma == 'h5555 && md == 8'hAA) ? 1 : 0;
        else if (mSeq == 1) mSeq = (ma == 'h2AAA && md == 8'h55) ? 2 : 0;
        else begin
          if (ma == 'h5555) begin
            if (md == 8'h90) mId = 1;
            else if (md == 8'hF0) mId = 0;
            else if (md == 8'hA0) begin mLoad = 1; mIdle = 0; end
          end
          mSeq = 0;
        end
      end
    end else if (mLoad) begin
      mIdle++;
      if (mIdle > BLC_CYC) begin mLoad = 0; mBusy = 1; mCnt = progCyc; end
    end
    if (!flOeN && !flCeN) begin
      if (mPrevOe || ma != mPrevAddr) begin rAddr.push_back(ma); rCyc.push_back(cyc); end
      if (mLoad) begin mLoad = 0; mBusy = 1; mCnt = progCyc; end
      mTog = !mTog;
    end
    if (mBusy) begin
      if (mCnt == 0) begin
        foreach (pend[k]) mem[k] = (k == corruptAddr) ? (pend[k] ^ 8'h01) : pend[k];
        pend.delete();
        mBusy = 0;
      end else mCnt--;
    end
    if (mId) rdVal = (ma == 0) ? 8'h1F : (ma == 1) ? 8'(devCode) : 8'h00;
    else if (mBusy) rdVal = {~mLast[7], mTog, mLast[5:0]};
    else rdVal = mem.exists(ma) ? mem[ma] : 8'hFF;
    flDin <= rdVal;
    mPrevWe = flWeN; mPrevOe = flOeN; mPrevAddr = ma;
  end

  // write pulse monitor (R5)
  always @(posedge clk) begin
    if (!flWeN) begin
      weRun++;
      if (!flOeN || flCeN) pulseViol++;
    end else if (weRun != 0) begin
      if (weRun != WE_CYC) pulseViol++;
      weRun = 0;
    end
  end

  // run watchdog
  initial begin
    repeat (190000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  task automatic model_clear();
    mem.delete(); pend.delete();
    wAddr.delete(); wData.delete(); wCyc.delete(); rAddr.delete(); rCyc.delete();
    mId = 0; mLoad = 0; mBusy = 0; mSeq = 0; mIdle = 0;
  endtask

  task automatic feed(int n, int seed, int stall);
    for (int g = 0; g < n && !feedStop; g++) begin
      if (stall > 0 && g % 5 == 2) begin srcValid = 0; repeat (stall) @(negedge clk); end
      srcValid = 1; srcData = pat(seed, g);
      while (!srcReady && !feedStop) @(negedge clk);
      if (!feedStop) @(negedge clk);
    end
    srcValid = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 60000 && !done; i++) @(negedge clk);
    feedStop = 1;
  endtask

  task automatic run_op(int code, int start, int pages, bit ver, int stall, int seed,
                        int pcyc, int corrupt, int nBytes);
    model_clear();
    devCode = code; progCyc = pcyc; corruptAddr = corrupt; feedStop = 0;
    startAddr = ADDR_W'(start); pageCnt = CNT_W'(pages); verifyEn = ver;
    startReq = 1; @(negedge clk); startReq = 0;
    fork
      feed(nBytes, seed, stall);
      wait_done();
    join
    repeat (5) @(negedge clk);
  endtask

  // compares the write log with the expected command and data sequence
  task automatic check_writes(string req, int base, int size, int pages, int seed);
    int ea[$], ed[$];
    int bad = 0;
    ea = '{'h5555, 'h2AAA, 'h5555, 'h5555, 'h2AAA, 'h5555};
    ed = '{'hAA, 'h55, 'h90, 'hAA, 'h55, 'hF0};
    for (int p = 0; p < pages; p++) begin
      ea.push_back('h5555); ed.push_back('hAA);
      ea.push_back('h2AAA); ed.push_back('h55);
      ea.push_back('h5555); ed.push_back('hA0);
      for (int i = 0; i < size; i++) begin
        ea.push_back(base + p * size + i); ed.push_back(int'(pat(seed, p * size + i)));
      end
    end
    chk(wAddr.size() == ea.size(), req, "write count", wAddr.size(), ea.size());
    for (int k = 0; k < ea.size() && k < wAddr.size(); k++)
      if (wAddr[k] != ea[k] || wData[k] != ed[k]) begin
        if (bad == 0) chk(0, req, $sformatf("write %0d addr/data", k), (wAddr[k] << 8) | wData[k],
                         (ea[k] << 8) | ed[k]);
        bad++;
      end
    if (bad == 0) chk(1, req, "write sequence", 0, 0);
  endtask

  task automatic test_reset();
    rstN = 0; repeat (3) @(negedge clk);
    chk(flCeN && flOeN && flWeN, "R10", "bus strobes in reset", {flCeN, flOeN, flWeN}, 3'b111);
    rstN = 1; @(negedge clk);
    chk(!busy && !done && !error && !timeout, "R10", "flags after reset",
        {busy, done, error, timeout}, 0);
  endtask

  task automatic test_page64();
    int maxGap = 0, badMem = 0, badRd = 0;
    run_op('hDC, 'h01234, 1, 0, 0, 3, 300, -1, 64);
    chk(done && !error && !timeout && !busy, "R11", "end flags", {done, error, timeout, busy}, 4'b1000);
    check_writes("R4", 'h01200, 64, 1, 3);
    chk(rAddr.size() > 0 && rAddr[0] == 1, "R1", "code read address", rAddr.size() > 0 ? rAddr[0] : -1, 1);
    chk(rCyc[0] - wCyc[2] >= TWC_CYC, "R1", "wait before code read", rCyc[0] - wCyc[2], TWC_CYC);
    chk(wCyc[6] - wCyc[5] >= TWC_CYC, "R2", "wait after exit", wCyc[6] - wCyc[5], TWC_CYC);
    for (int k = 10; k < wCyc.size(); k++) if (wCyc[k] - wCyc[k-1] > maxGap) maxGap = wCyc[k] - wCyc[k-1];
    chk(maxGap == WE_CYC + 2, "R5", "byte load spacing", maxGap, WE_CYC + 2);
    for (int k = 1; k < rAddr.size(); k++) if (rAddr[k] != 'h0123F) badRd++;
    chk(badRd == 0 && rAddr.size() > 1, "R7", "poll reads only last address", badRd, 0);
    for (int i = 0; i < 64; i++) if (!mem.exists('h01200 + i) || mem['h01200 + i] != pat(3, i)) badMem++;
    chk(badMem == 0, "R7", "array contents after poll", badMem, 0);
    repeat (20) @(negedge clk);
    chk(done && !busy, "R11", "done held", done, 1);
  endtask

  task automatic test_two_pages_verify_stall();
    int seen [int];
    int miss = 0, badMem = 0;
    run_op('hDA, 'h02000, 2, 1, 3, 11, 300, -1, 512);
    chk(done && !error && !timeout, "R9", "verify pass flags", {done, error, timeout}, 3'b100);
    check_writes("R6", 'h02000, 256, 2, 11);
    foreach (rAddr[k]) seen[rAddr[k]] = 1;
    for (int i = 0; i < 512; i++) if (!seen.exists('h02000 + i)) miss++;
    chk(miss == 0, "R9", "every byte read back", miss, 0);
    for (int i = 0; i < 512; i++) if (!mem.exists('h02000 + i) || mem['h02000 + i] != pat(11, i)) badMem++;
    chk(badMem == 0, "R6", "array after stalled source", badMem, 0);
  endtask

  task automatic test_bad_code();
    int a0 = 0;
    run_op('h77, 'h00000, 1, 0, 0, 5, 300, -1, 64);
    chk(done && error && !timeout, "R3", "unknown code flags", {done, error, timeout}, 3'b110);
    foreach (wData[k]) if (wData[k] == 'hA0) a0++;
    chk(wAddr.size() == 6 && a0 == 0, "R3", "no unlock after unknown code", wAddr.size(), 6);
  endtask

  task automatic test_code128();
    run_op('h5D, 'h00300, 0, 0, 0, 7, 300, -1, 256);
    chk(done && !error, "R3", "128 byte page flags", {done, error}, 2'b10);
    check_writes("R3", 'h00300, 128, 1, 7);
  endtask

  task automatic test_timeout();
    int n0;
    run_op('hDC, 'h00040, 1, 0, 0, 9, 100000, -1, 64);
    chk(done && timeout && !error, "R8", "timeout flags", {done, timeout, error}, 3'b110);
    chk(cyc - wCyc[wCyc.size()-1] >= WDOG_CYC, "R8", "poll duration", cyc - wCyc[wCyc.size()-1], WDOG_CYC);
    n0 = wAddr.size();
    repeat (200) @(negedge clk);
    chk(wAddr.size() == n0 && n0 == 6 + 3 + 64, "R8", "no writes after timeout", wAddr.size(), 73);
  endtask

  task automatic test_verify_fail();
    run_op('hA4, 'h04000, 2, 1, 0, 13, 300, 'h04005, 1024);
    chk(done && error && !timeout, "R9", "mismatch flags", {done, error, timeout}, 3'b110);
    chk(int'(errAddr) == 'h04005, "R9", "failing address", int'(errAddr), 'h04005);
    chk(wAddr.size() == 6 + 3 + 512, "R9", "second page not written", wAddr.size(), 521);
  endtask

  initial begin
    test_reset();
    test_page64();
    test_two_pages_verify_stall();
    test_bad_code();
    test_code128();
    test_timeout();
    test_verify_fail();
    chk(pulseViol == 0, "R5", "write pulse shape violations", pulseViol, 0);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule